// File: doc/BRIEF.md
# Multicycle Processor Sequencing Controller

This block sequences a small load/store processor that runs each instruction over several clock cycles and reuses one memory, one ALU and one register file across those cycles. It holds a 4-bit state and produces, in every cycle, the full set of datapath steering and write-enable lines: program-counter load, conditional PC load, memory address source, memory read and write strobes, register-file write data source, instruction-register load, PC next-value select, ALU function class, the two ALU operand selects, register-file write enable and register-file destination select.

The controller is a Moore machine, so its outputs depend on the current state alone. The 6-bit opcode field of the instruction register steers the next state only in two places: the decode state, which picks the instruction class, and the address-calculation state, which separates loads from stores. Loads take five cycles. Stores and register-register ALU operations take four. Branch-if-equal and jump take three. The datapath, memory and ALU function decoding live outside this block. The `rst_n` input clears the state asynchronously and is expected to be deasserted in step with `clk`.

Top module: `mc_seq_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after its release, the controller is in the fetch state and drives the fetch outputs (R2).
- R2: Fetch drives `pc_load`=1, `mem_rd_en`=1, `instr_load`=1, `mem_addr_from_alu`=0, `pc_next_sel`=00, `alu_func_sel`=00, `alu_a_from_reg`=0 and `alu_b_sel`=01. Every other control output is 0. The next state is always decode.
- R3: Decode drives `alu_b_sel`=11, `alu_a_from_reg`=0 and `alu_func_sel`=00, with all other outputs 0. From decode, opcode 6'h23 (load) or 6'h2B (store) goes to address calculation, 6'h00 goes to ALU execute, 6'h04 goes to branch and 6'h02 goes to jump.
- R4: Address calculation drives `alu_a_from_reg`=1, `alu_b_sel`=10 and `alu_func_sel`=00, with all other outputs 0.
- R5: Memory read drives `mem_rd_en`=1 and `mem_addr_from_alu`=1, then goes to load write-back. Memory write drives `mem_wr_en`=1 and `mem_addr_from_alu`=1, then returns to fetch. All other outputs are 0 in both states.
- R6: Load write-back drives `rf_wr_en`=1, `rf_data_from_mem`=1 and `rf_dest_rd`=0, with all other outputs 0, then returns to fetch.
- R7: ALU execute drives `alu_a_from_reg`=1, `alu_b_sel`=00 and `alu_func_sel`=10, then goes to ALU completion. ALU completion drives `rf_wr_en`=1, `rf_dest_rd`=1 and `rf_data_from_mem`=0, then returns to fetch. All other outputs are 0 in both states.
- R8: Branch drives `alu_a_from_reg`=1, `alu_b_sel`=00, `alu_func_sel`=01, `pc_load_if_eq`=1 and `pc_next_sel`=01. Jump drives `pc_load`=1 and `pc_next_sel`=10. Both states return to fetch, and all other outputs are 0 in both.
- R9: From one fetch cycle to the next is 5 cycles for a load, 4 for a store or ALU operation, and 3 for a branch or jump.
- R10: An opcode outside the five listed ones, seen in decode, returns the controller to fetch on the next cycle, so the round takes 2 cycles and no write strobe is raised.
- R11: The opcode input has no effect on the state sequence in any state other than decode and address calculation.
- R12: Address calculation dispatches on the opcode present in that cycle. Opcode 6'h23 goes to memory read, 6'h2B goes to memory write, and any other value returns to fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode_i | input | 6 | Opcode field of the instruction register |
| pc_load | output | 1 | Unconditional PC write enable |
| pc_load_if_eq | output | 1 | PC write enable qualified by the ALU equality flag |
| mem_addr_from_alu | output | 1 | Memory address source: 0 = PC, 1 = ALU result register |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| rf_data_from_mem | output | 1 | Register write data source: 0 = ALU result, 1 = memory data register |
| instr_load | output | 1 | Instruction register load enable |
| pc_next_sel | output | 2 | PC next value: 00 ALU, 01 ALU result register, 10 jump target |
| alu_func_sel | output | 2 | ALU function class: 00 add, 01 subtract, 10 from function field |
| alu_a_from_reg | output | 1 | ALU operand A: 0 = PC, 1 = register A |
| alu_b_sel | output | 2 | ALU operand B: 00 register B, 01 constant 4, 10 immediate, 11 shifted immediate |
| rf_wr_en | output | 1 | Register file write enable |
| rf_dest_rd | output | 1 | Register destination: 0 = rt field, 1 = rd field |

## Verification
The case that is hardest to reach from the ports is an opcode that changes between decode and address calculation. A real instruction register holds still across those cycles, so in normal use the second dispatch point only ever sees a load or store opcode. The stimulus therefore swaps the opcode exactly at that boundary: load to store, store to load, and load to an unlisted code. This shows that the second dispatch samples its own cycle's opcode and that a stray code falls back to fetch. Every one of the 64 opcodes is also run through decode, with a scrambled opcode driven in all non-dispatching states to show it is ignored.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  localparam int OPC_W = 6;
  localparam int ST_W  = 4;

  typedef enum logic [ST_W-1:0] {
    ST_FETCH  = 4'h0,
    ST_DECODE = 4'h1,
    ST_MEMADR = 4'h2,
    ST_MEMRD  = 4'h3,
    ST_LDWB   = 4'h4,
    ST_MEMWR  = 4'h5,
    ST_REXE   = 4'h6,
    ST_RDONE  = 4'h7,
    ST_BRANCH = 4'h8,
    ST_JUMP   = 4'h9
  } mcc_state_e;

  localparam logic [OPC_W-1:0] OP_ALU = 6'h00;
  localparam logic [OPC_W-1:0] OP_JMP = 6'h02;
  localparam logic [OPC_W-1:0] OP_BEQ = 6'h04;
  localparam logic [OPC_W-1:0] OP_LD  = 6'h23;
  localparam logic [OPC_W-1:0] OP_ST  = 6'h2B;

  // Opcode class flags, at most one set
  typedef struct packed {
    logic ld;
    logic st;
    logic alu;
    logic beq;
    logic jmp;
  } mcc_class_t;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_eq;
    logic       addr_alu;
    logic       mrd;
    logic       mwr;
    logic       wd_mem;
    logic       ir_ld;
    logic [1:0] pc_sel;
    logic [1:0] fn_sel;
    logic       a_reg;
    logic [1:0] b_sel;
    logic       rwr;
    logic       dst_rd;
  } mcc_ctrl_t;

endpackage

// File: rtl/mcc_op_class.sv
module mcc_op_class
  import mcc_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output mcc_class_t       cls
);

  always_comb begin
    cls     = '0;
    cls.ld  = (opcode == OP_LD);
    cls.st  = (opcode == OP_ST);
    cls.alu = (opcode == OP_ALU);
    cls.beq = (opcode == OP_BEQ);
    cls.jmp = (opcode == OP_JMP);
  end

endmodule

// File: rtl/mcc_next_state.sv
module mcc_next_state
  import mcc_pkg::*;
(
  input  mcc_state_e state_cur,
  input  mcc_class_t cls,
  output mcc_state_e state_nxt
);

  always_comb begin
    state_nxt = ST_FETCH;
    unique case (state_cur)
      ST_FETCH:  state_nxt = ST_DECODE;
      ST_DECODE: begin
        if (cls.ld || cls.st) state_nxt = ST_MEMADR;
        else if (cls.alu)     state_nxt = ST_REXE;
        else if (cls.beq)     state_nxt = ST_BRANCH;
        else if (cls.jmp)     state_nxt = ST_JUMP;
        else                  state_nxt = ST_FETCH;
      end
      ST_MEMADR: begin
        if (cls.ld)      state_nxt = ST_MEMRD;
        else if (cls.st) state_nxt = ST_MEMWR;
        else             state_nxt = ST_FETCH;
      end
      ST_MEMRD:  state_nxt = ST_LDWB;
      ST_REXE:   state_nxt = ST_RDONE;
      ST_LDWB, ST_MEMWR, ST_RDONE, ST_BRANCH, ST_JUMP:
                 state_nxt = ST_FETCH;
      default:   state_nxt = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mcc_ctrl_decode.sv
module mcc_ctrl_decode
  import mcc_pkg::*;
(
  input  mcc_state_e state_cur,
  output mcc_ctrl_t  ctrl
);

  always_comb begin
    ctrl = '0;
    unique case (state_cur)
      ST_FETCH: begin
        ctrl.mrd    = 1'b1;
        ctrl.ir_ld  = 1'b1;
        ctrl.pc_wr  = 1'b1;
        ctrl.b_sel  = 2'b01;
      end
      ST_DECODE: begin
        ctrl.b_sel  = 2'b11;
      end
      ST_MEMADR: begin
        ctrl.a_reg  = 1'b1;
        ctrl.b_sel  = 2'b10;
      end
      ST_MEMRD: begin
        ctrl.mrd      = 1'b1;
        ctrl.addr_alu = 1'b1;
      end
      ST_LDWB: begin
        ctrl.rwr    = 1'b1;
        ctrl.wd_mem = 1'b1;
      end
      ST_MEMWR: begin
        ctrl.mwr      = 1'b1;
        ctrl.addr_alu = 1'b1;
      end
      ST_REXE: begin
        ctrl.a_reg  = 1'b1;
        ctrl.fn_sel = 2'b10;
      end
      ST_RDONE: begin
        ctrl.rwr    = 1'b1;
        ctrl.dst_rd = 1'b1;
      end
      ST_BRANCH: begin
        ctrl.a_reg    = 1'b1;
        ctrl.fn_sel   = 2'b01;
        ctrl.pc_wr_eq = 1'b1;
        ctrl.pc_sel   = 2'b01;
      end
      ST_JUMP: begin
        ctrl.pc_wr  = 1'b1;
        ctrl.pc_sel = 2'b10;
      end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/mc_seq_ctrl.sv
module mc_seq_ctrl
  import mcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode_i,
  output logic             pc_load,
  output logic             pc_load_if_eq,
  output logic             mem_addr_from_alu,
  output logic             mem_rd_en,
  output logic             mem_wr_en,
  output logic             rf_data_from_mem,
  output logic             instr_load,
  output logic [1:0]       pc_next_sel,
  output logic [1:0]       alu_func_sel,
  output logic             alu_a_from_reg,
  output logic [1:0]       alu_b_sel,
  output logic             rf_wr_en,
  output logic             rf_dest_rd
);

  mcc_state_e state_q;
  mcc_state_e state_d;
  mcc_class_t op_cls;
  mcc_ctrl_t  ctrl;

  mcc_op_class u_cls (
    .opcode (opcode_i),
    .cls    (op_cls)
  );

  mcc_next_state u_nxt (
    .state_cur (state_q),
    .cls       (op_cls),
    .state_nxt (state_d)
  );

  mcc_ctrl_decode u_dec (
    .state_cur (state_q),
    .ctrl      (ctrl)
  );

  // State register, advances every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FETCH;
    else        state_q <= state_d;
  end

  assign pc_load           = ctrl.pc_wr;
  assign pc_load_if_eq     = ctrl.pc_wr_eq;
  assign mem_addr_from_alu = ctrl.addr_alu;
  assign mem_rd_en         = ctrl.mrd;
  assign mem_wr_en         = ctrl.mwr;
  assign rf_data_from_mem  = ctrl.wd_mem;
  assign instr_load        = ctrl.ir_ld;
  assign pc_next_sel       = ctrl.pc_sel;
  assign alu_func_sel      = ctrl.fn_sel;
  assign alu_a_from_reg    = ctrl.a_reg;
  assign alu_b_sel         = ctrl.b_sel;
  assign rf_wr_en          = ctrl.rwr;
  assign rf_dest_rd        = ctrl.dst_rd;

endmodule

// File: rtl/mc_seq_ctrl_chk.sv
module mc_seq_ctrl_chk
  import mcc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [OPC_W-1:0] opcode_i,
  input mcc_state_e       state_q,
  input logic             pc_load,
  input logic             pc_load_if_eq,
  input logic             mem_addr_from_alu,
  input logic             mem_rd_en,
  input logic             mem_wr_en,
  input logic             rf_data_from_mem,
  input logic             instr_load,
  input logic [1:0]       pc_next_sel,
  input logic [1:0]       alu_func_sel,
  input logic             alu_a_from_reg,
  input logic [1:0]       alu_b_sel,
  input logic             rf_wr_en,
  input logic             rf_dest_rd
);

  function automatic logic op_known(input logic [OPC_W-1:0] o);
    return (o == OP_ALU) || (o == OP_JMP) || (o == OP_BEQ) ||
           (o == OP_LD)  || (o == OP_ST);
  endfunction

  assert_fetch_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
    instr_load |-> (pc_load && mem_rd_en && !mem_addr_from_alu &&
                    pc_next_sel == 2'b00 && alu_b_sel == 2'b01));

  assert_fetch_then_decode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    instr_load |=> (!instr_load && alu_b_sel == 2'b11 && !alu_a_from_reg));

  assert_load_dispatch_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MEMADR && opcode_i == OP_LD) |=> (mem_rd_en && mem_addr_from_alu));

  assert_mem_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

  assert_load_writeback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && mem_addr_from_alu) |=> (rf_wr_en && rf_data_from_mem && !rf_dest_rd));

  assert_alu_complete_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_func_sel == 2'b10) |=> (rf_wr_en && rf_dest_rd && !rf_data_from_mem));

  assert_pc_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pc_load, pc_load_if_eq}));

  assert_terminal_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en || rf_wr_en || pc_load_if_eq || (pc_load && !instr_load)) |=> instr_load);

  assert_unknown_op_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DECODE && !op_known(opcode_i)) |=> instr_load);

endmodule

bind mc_seq_ctrl mc_seq_ctrl_chk u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .opcode_i          (opcode_i),
  .state_q           (state_q),
  .pc_load           (pc_load),
  .pc_load_if_eq     (pc_load_if_eq),
  .mem_addr_from_alu (mem_addr_from_alu),
  .mem_rd_en         (mem_rd_en),
  .mem_wr_en         (mem_wr_en),
  .rf_data_from_mem  (rf_data_from_mem),
  .instr_load        (instr_load),
  .pc_next_sel       (pc_next_sel),
  .alu_func_sel      (alu_func_sel),
  .alu_a_from_reg    (alu_a_from_reg),
  .alu_b_sel         (alu_b_sel),
  .rf_wr_en          (rf_wr_en),
  .rf_dest_rd        (rf_dest_rd)
);

// File: tb/sim_mc_seq_ctrl.sv
module sim_mc_seq_ctrl;

  localparam int CLK_P = 10;

  // Bench-side step identifiers
  localparam int S_FET = 0, S_DEC = 1, S_ADR = 2, S_MRD = 3, S_LWB = 4,
                 S_MWR = 5, S_REX = 6, S_RDN = 7, S_BRA = 8, S_JMP = 9;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic [5:0] opcode = 6'h00;
  logic       pc_load, pc_load_if_eq, mem_addr_from_alu, mem_rd_en, mem_wr_en;
  logic       rf_data_from_mem, instr_load, alu_a_from_reg, rf_wr_en, rf_dest_rd;
  logic [1:0] pc_next_sel, alu_func_sel, alu_b_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  mc_seq_ctrl u0 (
    .clk (clk), .rst_n (rst_n), .opcode_i (opcode),
    .pc_load (pc_load), .pc_load_if_eq (pc_load_if_eq),
    .mem_addr_from_alu (mem_addr_from_alu), .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en), .rf_data_from_mem (rf_data_from_mem),
    .instr_load (instr_load), .pc_next_sel (pc_next_sel),
    .alu_func_sel (alu_func_sel), .alu_a_from_reg (alu_a_from_reg),
    .alu_b_sel (alu_b_sel), .rf_wr_en (rf_wr_en), .rf_dest_rd (rf_dest_rd)
  );

  function automatic logic [15:0] mk(input bit pcl, pce, ad, mr, mw, wd, ir,
                                     input bit [1:0] src, fn, input bit a,
                                     input bit [1:0] b, input bit rw, rd);
    return {pcl, pce, ad, mr, mw, wd, ir, src, fn, a, b, rw, rd};
  endfunction

  function automatic logic [15:0] expect_vec(input int s);
    case (s)
      S_FET:   return mk(1,0,0,1,0,0,1, 2'b00, 2'b00, 0, 2'b01, 0,0);
      S_DEC:   return mk(0,0,0,0,0,0,0, 2'b00, 2'b00, 0, 2'b11, 0,0);
      S_ADR:   return mk(0,0,0,0,0,0,0, 2'b00, 2'b00, 1, 2'b10, 0,0);
      S_MRD:   return mk(0,0,1,1,0,0,0, 2'b00, 2'b00, 0, 2'b00, 0,0);
      S_LWB:   return mk(0,0,0,0,0,1,0, 2'b00, 2'b00, 0, 2'b00, 1,0);
      S_MWR:   return mk(0,0,1,0,1,0,0, 2'b00, 2'b00, 0, 2'b00, 0,0);
      S_REX:   return mk(0,0,0,0,0,0,0, 2'b00, 2'b10, 1, 2'b00, 0,0);
      S_RDN:   return mk(0,0,0,0,0,0,0, 2'b00, 2'b00, 0, 2'b00, 1,1);
      S_BRA:   return mk(0,1,0,0,0,0,0, 2'b01, 2'b01, 1, 2'b00, 0,0);
      default: return mk(1,0,0,0,0,0,0, 2'b10, 2'b00, 0, 2'b00, 0,0);
    endcase
  endfunction

  function automatic logic [15:0] got_vec();
    return {pc_load, pc_load_if_eq, mem_addr_from_alu, mem_rd_en, mem_wr_en,
            rf_data_from_mem, instr_load, pc_next_sel, alu_func_sel,
            alu_a_from_reg, alu_b_sel, rf_wr_en, rf_dest_rd};
  endfunction

  task automatic chk(input int s, input string req);
    logic [15:0] g;
    g = got_vec();
    checks++;
    if (g !== expect_vec(s)) begin
      fails++;
      $display("FAIL %s step=%0d actual=%b expected=%b", req, s, g, expect_vec(s));
    end
  endtask

  task automatic chk_int(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(inout int cyc);
    @(negedge clk);
    cyc++;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int cyc;
    #1 rst_n = 1'b0;
    @(negedge clk);
    chk(S_FET, "R1 reset held");
    @(negedge clk);
    rst_n = 1'b1;
    chk(S_FET, "R1 after release");

    // Sweep every opcode through decode; R11 noise elsewhere
    for (int op = 0; op < 64; op++) begin
      logic [5:0] o, noise;
      o = 6'(op);
      noise = ~o;
      cyc = 0;
      chk(S_FET, "R2");
      opcode = noise;
      tick(cyc);
      chk(S_DEC, "R3");
      opcode = o;
      tick(cyc);
      if (o == 6'h23) begin
        chk(S_ADR, "R4 load");
        tick(cyc);
        opcode = noise;
        chk(S_MRD, "R5 read");
        tick(cyc);
        chk(S_LWB, "R6 writeback R11");
        tick(cyc);
        chk_int(cyc, 5, "R9 load cycles");
      end else if (o == 6'h2B) begin
        chk(S_ADR, "R4 store");
        tick(cyc);
        opcode = noise;
        chk(S_MWR, "R5 write");
        tick(cyc);
        chk_int(cyc, 4, "R9 store cycles");
      end else if (o == 6'h00) begin
        opcode = noise;
        chk(S_REX, "R7 execute R11");
        tick(cyc);
        chk(S_RDN, "R7 complete");
        tick(cyc);
        chk_int(cyc, 4, "R9 alu cycles");
      end else if (o == 6'h04) begin
        opcode = noise;
        chk(S_BRA, "R8 branch");
        tick(cyc);
        chk_int(cyc, 3, "R9 branch cycles");
      end else if (o == 6'h02) begin
        opcode = noise;
        chk(S_JMP, "R8 jump");
        tick(cyc);
        chk_int(cyc, 3, "R9 jump cycles");
      end else begin
        chk(S_FET, "R10 unknown returns");
        chk_int(cyc, 2, "R10 round length");
      end
    end

    // R12: opcode changed between decode and address calculation
    cyc = 0;
    opcode = 6'h23; tick(cyc);
    chk(S_DEC, "R12 setup");
    tick(cyc);
    chk(S_ADR, "R12 at addr");
    opcode = 6'h2B; tick(cyc);
    chk(S_MWR, "R12 load to store");
    tick(cyc);
    chk(S_FET, "R12 store end");

    opcode = 6'h2B; tick(cyc); tick(cyc);
    chk(S_ADR, "R12 at addr");
    opcode = 6'h23; tick(cyc);
    chk(S_MRD, "R12 store to load");
    tick(cyc);
    chk(S_LWB, "R12 load wb");
    tick(cyc);

    opcode = 6'h23; tick(cyc); tick(cyc);
    chk(S_ADR, "R12 at addr");
    opcode = 6'h3F; tick(cyc);
    chk(S_FET, "R12 stray code");

    // R1: reset asserted mid-instruction
    opcode = 6'h23; tick(cyc); tick(cyc); tick(cyc);
    chk(S_MRD, "R1 setup");
    #1 rst_n = 1'b0;
    #1 chk(S_FET, "R1 async clear");
    @(negedge clk);
    chk(S_FET, "R1 held across edge");
    rst_n = 1'b1;
    @(negedge clk);
    chk(S_DEC, "R1 resume");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule